// File: doc/BRIEF.md
# Embedded-Clock Pixel Frame Serializer

The block takes one parallel video word per pixel period and sends it as a fixed 28-slot serial frame. The word holds 24 colour bits (red, green and blue, 8 bits each) and the horizontal sync, vertical sync and data-enable timing signals. Each frame begins with a fixed high clock bit and ends with a fixed low clock bit. A receiver therefore sees a guaranteed low-to-high edge at every frame boundary and can recover the pixel clock from it.

The 24 payload bits are XORed with an additive LFSR keystream. They are then DC-balanced by a running-disparity rule that may invert the whole field. Two control bits in the middle of the frame carry the data-enable state and, through whether they differ, the inversion flag. During blanking the payload field carries the two sync signals.

The block runs on one clock at the serial bit rate. A slot enable, `slotEn`, advances the frame by one bit. The block produces the pixel-rate clock `pixClk` for the video source. The source must hold its word stable across the rising edge of `pixClk`.

Top module: `pixelFrameSerializer`

## Requirements
- R1: A frame is 28 enabled slots long. `pixClk` is high for slots 0 to 13 and low for slots 14 to 27. The input word is captured on the enabled edge that starts slot 0, which is the edge on which `pixClk` rises.
- R2: Slot 0 of every frame is 1 and slot 27 is 0.
- R3: The payload is {red, green, blue}, each colour MSB first, 24 bits. Slots 1 to 12 carry payload bits 23 down to 12, slot 13 carries control bit A, slot 14 carries control bit B, and slots 15 to 26 carry payload bits 11 down to 0.
- R4: The payload is XORed with a keystream from a 16-bit LFSR. The LFSR is loaded with 16'hACE1 at reset. Each step outputs bit 15, then shifts left and inserts the XOR of bits 15, 13, 12 and 10. The first output of a frame goes to payload bit 23. The LFSR takes 24 steps per frame.
- R5: Control bit A equals data enable. Control bit B equals data enable XOR the inversion flag.
- R6: The running disparity starts at 0. It accumulates, over all sent payload fields, the count of ones minus the count of zeros. The scrambled field is inverted when the current disparity and the field's own disparity are both nonzero and of the same sign.
- R7: The running disparity never leaves the range -24 to +24.
- R8: In 18-bit mode (`mode18`=1) the two low bits of each colour are sent as zero before scrambling.
- R9: When data enable is 0, the payload is {hSync, vSync, 22 zeros} and the colour inputs have no effect.
- R10: While `slotEn` is 0, `serOut`, `pixClk` and all frame state hold their values.
- R11: After reset `serOut` and `pixClk` are 0. The first enabled slot after reset starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotEn | input | 1 | Advances one serial slot |
| mode18 | input | 1 | 18-bit colour mode |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hSync | input | 1 | Horizontal sync |
| vSync | input | 1 | Vertical sync |
| dataEn | input | 1 | Active video |
| serOut | output | 1 | Serial frame output |
| pixClk | output | 1 | Pixel-rate clock for the source |

## Verification
The bench deframes the serial stream itself, aligned on the rising edge of `pixClk`. It undoes the scrambling and inversion with its own keystream and disparity model.

Long runs of all-ones words test the disparity rule. A design that inverts on the wrong sign, or never inverts, lets the bound in R7 drift and mismatches the inversion flag. Blanking words carry busy colour inputs, so a design that leaks colour into the sync field fails. The 18-bit words carry set low bits, so a design that skips the masking fails.

Gapped slot enables catch a design that shifts, or moves `pixClk`, without an enable. The first frame after reset checks that the keystream starts from the seed.

// File: rtl/pfsPkg.sv
package pfsPkg;
  // strobes from the slot sequencer to the frame datapath
  typedef struct packed {
    logic loadFrame;  // enabled edge that begins slot 0
    logic shiftBit;   // enabled edge inside a frame
  } pfsStrobe_t;
endpackage

// File: rtl/pfsCtrl.sv
module pfsCtrl
  import pfsPkg::*;
#(
  parameter int FRAME_W = 28
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotEn,
  output pfsStrobe_t strobe,
  output logic       pixClk,
  output logic       lastSlot
);
  localparam int SLOT_W = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);
  localparam logic [SLOT_W-1:0] HALF_SLOT = SLOT_W'(FRAME_W / 2);

  logic [SLOT_W-1:0] slotCnt;

  assign lastSlot         = (slotCnt == LAST_SLOT);
  assign strobe.loadFrame = slotEn && lastSlot;
  assign strobe.shiftBit  = slotEn && !lastSlot;
  assign pixClk           = (slotCnt < HALF_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= LAST_SLOT;
    end else if (slotEn) begin
      slotCnt <= lastSlot ? '0 : slotCnt + 1'b1;
    end
  end

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= LAST_SLOT);

  // R1
  pix_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixClk) |-> $past(strobe.loadFrame));

  // R10
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotEn |=> $stable(pixClk));
endmodule

// File: rtl/pfsScrambler.sv
module pfsScrambler #(
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter int              KEY_W  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  output logic [KEY_W-1:0] key
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] stateNext;

  // KEY_W steps of the Fibonacci register, first output lands in the MSB
  always_comb begin
    logic [LFSR_W-1:0] walk;
    walk = state;
    key  = '0;
    for (int i = 0; i < KEY_W; i++) begin
      key[KEY_W-1-i] = walk[LFSR_W-1];
      walk = {walk[LFSR_W-2:0], ^(walk & TAPS)};
    end
    stateNext = walk;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        state <= SEED;
    else if (advance) state <= stateNext;
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);
endmodule

// File: rtl/pfsDatapath.sv
module pfsDatapath
  import pfsPkg::*;
#(
  parameter int              COLOR_W   = 8,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rstN,
  input  pfsStrobe_t         strobe,
  input  logic               lastSlot,
  input  logic               mode18,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hSync,
  input  logic               vSync,
  input  logic               dataEn,
  output logic               serOut
);
  localparam int PAYLOAD_W = 3 * COLOR_W;
  localparam int HALF_W    = PAYLOAD_W / 2;
  localparam int FRAME_W   = PAYLOAD_W + 4;
  localparam int ONES_W    = $clog2(PAYLOAD_W + 1);
  localparam int DISP_W    = ONES_W + 2;
  localparam int DISP_MAX  = PAYLOAD_W;
  localparam logic [COLOR_W-1:0] MASK18 = {{(COLOR_W-2){1'b1}}, 2'b00};

  logic [PAYLOAD_W-1:0] keyStream;
  logic [PAYLOAD_W-1:0] rawWord;
  logic [PAYLOAD_W-1:0] scrWord;
  logic [PAYLOAD_W-1:0] sentWord;
  logic [ONES_W-1:0]    onesCnt;
  logic signed [DISP_W-1:0] wordDisp;
  logic signed [DISP_W-1:0] runDisp;
  logic signed [DISP_W-1:0] runDispNext;
  logic                 invert;
  logic                 ctlA;
  logic                 ctlB;
  logic [FRAME_W-1:0]   newFrame;
  logic [FRAME_W-1:0]   frameReg;

  pfsScrambler #(
    .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .KEY_W(PAYLOAD_W)
  ) i_scr (
    .clk    (clk),
    .rstN   (rstN),
    .advance(strobe.loadFrame),
    .key    (keyStream)
  );

  // payload word: colours in active video, syncs during blanking
  always_comb begin
    if (!dataEn) begin
      rawWord = {hSync, vSync, {(PAYLOAD_W-2){1'b0}}};
    end else if (mode18) begin
      rawWord = {red & MASK18, green & MASK18, blue & MASK18};
    end else begin
      rawWord = {red, green, blue};
    end
  end

  assign scrWord = rawWord ^ keyStream;

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < PAYLOAD_W; i++) onesCnt = onesCnt + ONES_W'(scrWord[i]);
  end

  assign wordDisp    = DISP_W'({onesCnt, 1'b0}) - DISP_W'(PAYLOAD_W);
  assign invert      = ((runDisp > 0) && (wordDisp > 0)) ||
                       ((runDisp < 0) && (wordDisp < 0));
  assign sentWord    = invert ? ~scrWord : scrWord;
  assign runDispNext = invert ? runDisp - wordDisp : runDisp + wordDisp;
  assign ctlA        = dataEn;
  assign ctlB        = dataEn ^ invert;

  assign newFrame = {1'b1, sentWord[PAYLOAD_W-1:HALF_W], ctlA, ctlB,
                     sentWord[HALF_W-1:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
      runDisp  <= '0;
    end else if (strobe.loadFrame) begin
      frameReg <= newFrame;
      runDisp  <= runDispNext;
    end else if (strobe.shiftBit) begin
      frameReg <= {frameReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign serOut = frameReg[FRAME_W-1];

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> serOut);

  // R2
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastSlot |-> !serOut);

  // R7
  disp_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runDisp <= DISP_MAX) && (runDisp >= -DISP_MAX));

  // R6
  disp_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFrame && runDisp > 0) |=> runDisp <= $past(runDisp));

  // R6
  disp_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFrame && runDisp < 0) |=> runDisp >= $past(runDisp));

  // R10
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadFrame || strobe.shiftBit) |=> $stable(serOut));
endmodule

// File: rtl/pixelFrameSerializer.sv
module pixelFrameSerializer
  import pfsPkg::*;
#(
  parameter int              COLOR_W   = 8,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotEn,
  input  logic               mode18,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hSync,
  input  logic               vSync,
  input  logic               dataEn,
  output logic               serOut,
  output logic               pixClk
);
  localparam int FRAME_W = 3 * COLOR_W + 4;

  pfsStrobe_t strobe;
  logic       lastSlot;

  pfsCtrl #(.FRAME_W(FRAME_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .slotEn  (slotEn),
    .strobe  (strobe),
    .pixClk  (pixClk),
    .lastSlot(lastSlot)
  );

  pfsDatapath #(
    .COLOR_W(COLOR_W), .LFSR_W(LFSR_W),
    .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .lastSlot(lastSlot),
    .mode18  (mode18),
    .red     (red),
    .green   (green),
    .blue    (blue),
    .hSync   (hSync),
    .vSync   (vSync),
    .dataEn  (dataEn),
    .serOut  (serOut)
  );
endmodule

// File: tb/test_pixelFrameSerializer.sv
module test_pixelFrameSerializer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slotEn = 1'b0;
  logic       mode18 = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       hSync = 1'b0, vSync = 1'b0, dataEn = 1'b0;
  logic       serOut, pixClk;

  int checks = 0;
  int errors = 0;
  logic enAtEdge = 1'b0;
  logic prevPix = 1'b0;
  logic [15:0] lfsrM = 16'hACE1;
  int rdM = 0;
  int rdStream = 0;

  pixelFrameSerializer i_pixelFrameSerializer (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .mode18(mode18),
    .red(red), .green(green), .blue(blue),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .serOut(serOut), .pixClk(pixClk)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) enAtEdge <= slotEn;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // waits for the frame start (pixClk rise), then gathers 28 enabled slots
  task automatic collectFrame(input bit gaps, output logic [27:0] bits,
                              output logic [27:0] pix, output int holdErr);
    int n = 1;
    int cyc = 0;
    holdErr = 0;
    while (1) begin
      @(negedge clk);
      if (enAtEdge) begin
        if (pixClk && !prevPix) break;
        prevPix = pixClk;
      end
    end
    bits[27] = serOut;
    pix[27]  = pixClk;
    while (n < 28) begin
      if (gaps) slotEn = (cyc % 3 != 1);
      cyc++;
      @(negedge clk);
      if (enAtEdge) begin
        bits[27-n] = serOut;
        pix[27-n]  = pixClk;
        n++;
      end else if (serOut !== bits[28-n] || pixClk !== pix[28-n]) begin
        holdErr++;
      end
    end
    slotEn  = 1'b1;
    prevPix = 1'b0;
  endtask

  task automatic sendWord(input logic [7:0] r, input logic [7:0] g,
                          input logic [7:0] b, input logic hs, input logic vs,
                          input logic de, input logic m18, input bit gaps,
                          input string req);
    logic [27:0] bits, pix;
    logic [23:0] expRaw, key, scr, rx;
    logic [7:0]  m;
    int hold, ones, d, sum;
    logic expInv, rxInv;
    red = r; green = g; blue = b; hSync = hs; vSync = vs;
    dataEn = de; mode18 = m18; slotEn = 1'b1;
    m = m18 ? 8'hFC : 8'hFF;
    expRaw = de ? {r & m, g & m, b & m} : {hs, vs, 22'b0};
    // keystream model (R4)
    for (int i = 0; i < 24; i++) begin
      key[23-i] = lfsrM[15];
      lfsrM = {lfsrM[14:0], lfsrM[15] ^ lfsrM[13] ^ lfsrM[12] ^ lfsrM[10]};
    end
    scr = expRaw ^ key;
    ones = $countones(scr);
    d = 2 * ones - 24;
    expInv = (rdM > 0 && d > 0) || (rdM < 0 && d < 0);
    rdM = expInv ? rdM - d : rdM + d;
    collectFrame(gaps, bits, pix, hold);
    // bits[27] is slot 0, bits[0] is slot 27
    check(bits[27] == 1'b1 && bits[0] == 1'b0, "R2", "clock bits",
          {bits[27], bits[0]}, 2'b10);
    check(pix == 28'hFFFC000, "R1", "pixClk shape", pix, 28'hFFFC000);
    check(bits[14] == de, "R5", "control A", bits[14], de);
    rxInv = bits[14] ^ bits[13];
    check(rxInv == expInv, "R6", "inversion flag", rxInv, expInv);
    rx = {bits[26:15], bits[12:1]};
    sum = $countones(rx);
    rdStream += 2 * sum - 24;
    check(rdStream <= 24 && rdStream >= -24, "R7", "running disparity",
          rdStream, 24);
    rx = rx ^ (rxInv ? 24'hFFFFFF : 24'h0) ^ key;
    check(rx == expRaw, req, "descrambled payload (R3 R4)", rx, expRaw);
    if (gaps) check(hold == 0, "R10", "hold while slotEn low", hold, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0; slotEn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(serOut == 1'b0, "R11", "serOut after reset", serOut, 0);
    check(pixClk == 1'b0, "R11", "pixClk after reset", pixClk, 0);
    // first enabled slot starts a frame keyed from the seed
    sendWord(8'h5A, 8'hC3, 8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
  endtask

  task automatic testActive();
    sendWord(8'hFF, 8'hFF, 8'hFF, 0, 0, 1, 0, 0, "R3");
    sendWord(8'h00, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R3");
    sendWord(8'hA5, 8'h3C, 8'h0F, 1, 1, 1, 0, 0, "R3");
    sendWord(8'h12, 8'h34, 8'h56, 0, 0, 1, 0, 0, "R4");
    sendWord(8'h80, 8'h01, 8'h7E, 0, 1, 1, 0, 0, "R4");
  endtask

  task automatic testMode18();
    sendWord(8'hFF, 8'hFF, 8'hFF, 0, 0, 1, 1, 0, "R8");
    sendWord(8'hC7, 8'h2B, 8'h93, 0, 0, 1, 1, 0, "R8");
  endtask

  task automatic testBlanking();
    sendWord(8'hFF, 8'h77, 8'h3B, 0, 0, 0, 0, 0, "R9");
    sendWord(8'hE1, 8'hFF, 8'h9D, 1, 0, 0, 0, 0, "R9");
    sendWord(8'h6B, 8'h55, 8'hFF, 0, 1, 0, 1, 0, "R9");
    sendWord(8'hFF, 8'hFF, 8'hFF, 1, 1, 0, 0, 0, "R9");
  endtask

  task automatic testDisparity();
    for (int i = 0; i < 8; i++) sendWord(8'hFF, 8'hFF, 8'hFF, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 8; i++) sendWord(8'h00, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R7");
  endtask

  task automatic testGaps();
    sendWord(8'h9C, 8'h4E, 8'h27, 0, 0, 1, 0, 1, "R10");
    sendWord(8'h31, 8'hD2, 8'hF0, 1, 0, 0, 0, 1, "R10");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testActive();
    testMode18();
    testBlanking();
    testDisparity();
    testGaps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule